// File: doc/BRIEF.md
# Longest Prefix Match Route Lookup

This block resolves the egress port for a destination address in a connectionless forwarding path. It holds a small route table. Each slot carries a valid flag, an address prefix, a prefix length and an egress port number. For every destination address offered on its lookup input, it compares the address against all slots in parallel. A slot matches when the address and the prefix agree in their leading `length` bits. Of the matching slots, the one with the greatest length decides the port.

Lookups flow through a two-stage pipeline with a valid/ready handshake on both sides. One lookup can be accepted per cycle. The pipeline stalls cleanly when the consumer withholds ready. Lookups are independent of one another. The table is loaded through a simple single-cycle write port. A slot of length zero acts as the default route. When nothing matches, the block reports a miss with port zero.

Top module: `lpm_lookup`

## Requirements
- R1: While and after reset, `out_valid` is 0, `in_ready` is 1, and every slot is invalid, so the first lookup after reset misses.
- R2: A valid slot matches an address when their leading `length` bits are equal. Prefix bits below the length are ignored. For example, a /16 slot matches any address that agrees in bits 31..16, and a /24 slot matches any address that agrees in bits 31..8.
- R3: When several valid slots match, the result is the port of the matching slot with the largest length.
- R4: When the largest length is shared by several matching slots, the slot with the lowest index wins.
- R5: A valid slot of length 0 matches every address, so it serves as the default route.
- R6: When no valid slot matches, `out_hit` is 0 and `out_port` is 0.
- R7: A slot written with `wr_valid` = 0 takes part in no match.
- R8: A lookup presented in cycle c with `in_ready` = 1 has its result on the outputs in cycle c+2, provided `out_ready` stays 1. Back-to-back lookups are accepted one per cycle.
- R9: While `out_valid` = 1 and `out_ready` = 0, the outputs hold their values. Once both pipeline stages are full, `in_ready` is 0.
- R10: A table write in cycle c is seen by lookups accepted in cycle c+1 or later. A lookup accepted in cycle c itself uses the earlier contents.
- R11: A written length above the address width is stored as the address width, so it ties with a full-width slot of equal prefix.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write one table slot this cycle |
| wr_idx | input | IDX_W (4) | Slot index to write |
| wr_valid | input | 1 | Valid flag stored in the slot |
| wr_prefix | input | ADDR_W (32) | Prefix stored in the slot |
| wr_len | input | LEN_W (6) | Prefix length, 0 to ADDR_W |
| wr_port | input | PORT_W (4) | Egress port stored in the slot |
| in_valid | input | 1 | Lookup request present |
| in_ready | output | 1 | Lookup request can be accepted |
| in_addr | input | ADDR_W (32) | Destination address to resolve |
| out_valid | output | 1 | Lookup result present |
| out_ready | input | 1 | Consumer takes the result |
| out_hit | output | 1 | At least one valid slot matched |
| out_port | output | PORT_W (4) | Egress port of the winner, 0 on a miss |

## Verification
The bench builds the block with its default parameters: 32-bit addresses, 16 slots and 4-bit ports. With 16 slots, the bench can place equal-length routes at widely separated indices, and can keep a default route at the last slot beneath longer routes in lower slots. The 6-bit length field allows values above 32, which exercises the clamping rule against a /32 host route. Because the address is 32 bits wide, the /16, /24 and /32 patterns can be written as dotted-quad routes, with stray bits below the prefix length.

// File: rtl/lpm_pkg.sv
package lpm_pkg;

  // Width used to compare prefix lengths independently of LEN_W.
  localparam int CMP_W = 8;

  // Saturate a requested length at the address width.
  function automatic int unsigned clamp_len(input int unsigned len, input int unsigned width);
    return (len > width) ? width : len;
  endfunction

  // Candidate replaces the current best only when strictly longer,
  // so among equal lengths the earliest (lowest) index is kept.
  function automatic logic beats(input logic have_best,
                                 input logic [CMP_W-1:0] cand_len,
                                 input logic [CMP_W-1:0] best_len);
    return !have_best || (cand_len > best_len);
  endfunction

endpackage

// File: rtl/lpm_table.sv
module lpm_table #(
  parameter int ENTRIES = 16,
  parameter int ADDR_W  = 32,
  parameter int LEN_W   = 6,
  parameter int PORT_W  = 4,
  parameter int IDX_W   = 4
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              wr_en,
  input  logic [IDX_W-1:0]                  wr_idx,
  input  logic                              wr_valid,
  input  logic [ADDR_W-1:0]                 wr_prefix,
  input  logic [LEN_W-1:0]                  wr_len,
  input  logic [PORT_W-1:0]                 wr_port,
  output logic [ENTRIES-1:0]                tbl_valid,
  output logic [ENTRIES-1:0][ADDR_W-1:0]    tbl_prefix,
  output logic [ENTRIES-1:0][LEN_W-1:0]     tbl_len,
  output logic [ENTRIES-1:0][PORT_W-1:0]    tbl_port
);

  logic [LEN_W-1:0] len_sat;
  assign len_sat = LEN_W'(lpm_pkg::clamp_len(int'(wr_len), ADDR_W));

  for (genvar i = 0; i < ENTRIES; i++) begin : g_slot
    logic sel;
    assign sel = wr_en && (wr_idx == IDX_W'(i));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        tbl_valid[i]  <= 1'b0;
        tbl_prefix[i] <= '0;
        tbl_len[i]    <= '0;
        tbl_port[i]   <= '0;
      end else if (sel) begin
        tbl_valid[i]  <= wr_valid;
        tbl_prefix[i] <= wr_prefix;
        tbl_len[i]    <= len_sat;
        tbl_port[i]   <= wr_port;
      end
    end
  end

endmodule

// File: rtl/lpm_match.sv
module lpm_match #(
  parameter int ENTRIES = 16,
  parameter int ADDR_W  = 32,
  parameter int LEN_W   = 6
) (
  input  logic [ADDR_W-1:0]              addr,
  input  logic [ENTRIES-1:0]             tbl_valid,
  input  logic [ENTRIES-1:0][ADDR_W-1:0] tbl_prefix,
  input  logic [ENTRIES-1:0][LEN_W-1:0]  tbl_len,
  output logic [ENTRIES-1:0]             hit_vec
);

  // Ones in the top `len` bit positions of an ADDR_W-wide word.
  function automatic logic [ADDR_W-1:0] lead_mask(input logic [LEN_W-1:0] len);
    logic [ADDR_W-1:0] m;
    for (int b = 0; b < ADDR_W; b++) begin
      m[b] = ((b + int'(len)) >= ADDR_W);
    end
    return m;
  endfunction

  for (genvar i = 0; i < ENTRIES; i++) begin : g_cmp
    logic [ADDR_W-1:0] diff;
    assign diff       = (addr ^ tbl_prefix[i]) & lead_mask(tbl_len[i]);
    assign hit_vec[i] = tbl_valid[i] && (diff == '0);
  end

endmodule

// File: rtl/lpm_select.sv
module lpm_select #(
  parameter int ENTRIES = 16,
  parameter int LEN_W   = 6,
  parameter int PORT_W  = 4
) (
  input  logic [ENTRIES-1:0]             hit_vec,
  input  logic [ENTRIES-1:0][LEN_W-1:0]  tbl_len,
  input  logic [ENTRIES-1:0][PORT_W-1:0] tbl_port,
  output logic                           any_hit,
  output logic [PORT_W-1:0]              win_port
);

  logic [lpm_pkg::CMP_W-1:0] best_len;

  always_comb begin
    any_hit  = 1'b0;
    best_len = '0;
    win_port = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (hit_vec[i] &&
          lpm_pkg::beats(any_hit, lpm_pkg::CMP_W'(tbl_len[i]), best_len)) begin
        any_hit  = 1'b1;
        best_len = lpm_pkg::CMP_W'(tbl_len[i]);
        win_port = tbl_port[i];
      end
    end
  end

endmodule

// File: rtl/lpm_lookup.sv
module lpm_lookup #(
  parameter int ENTRIES = 16,
  parameter int ADDR_W  = 32,
  parameter int PORT_W  = 4,
  parameter int LEN_W   = $clog2(ADDR_W + 1),
  parameter int IDX_W   = $clog2(ENTRIES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic              wr_valid,
  input  logic [ADDR_W-1:0] wr_prefix,
  input  logic [LEN_W-1:0]  wr_len,
  input  logic [PORT_W-1:0] wr_port,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [ADDR_W-1:0] in_addr,
  output logic              out_valid,
  input  logic              out_ready,
  output logic              out_hit,
  output logic [PORT_W-1:0] out_port
);

  logic [ENTRIES-1:0]             tbl_valid;
  logic [ENTRIES-1:0][ADDR_W-1:0] tbl_prefix;
  logic [ENTRIES-1:0][LEN_W-1:0]  tbl_len;
  logic [ENTRIES-1:0][PORT_W-1:0] tbl_port;
  logic [ENTRIES-1:0]             hit_vec;
  logic                           any_hit;
  logic [PORT_W-1:0]              win_port;

  // Named pipeline events.
  logic fire_in;
  logic s2_free;
  logic s1_vld;
  logic s1_hit;
  logic [PORT_W-1:0] s1_port;

  lpm_table #(
    .ENTRIES(ENTRIES), .ADDR_W(ADDR_W), .LEN_W(LEN_W),
    .PORT_W(PORT_W), .IDX_W(IDX_W)
  ) u_table (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_valid(wr_valid),
    .wr_prefix(wr_prefix), .wr_len(wr_len), .wr_port(wr_port),
    .tbl_valid(tbl_valid), .tbl_prefix(tbl_prefix),
    .tbl_len(tbl_len), .tbl_port(tbl_port)
  );

  // Compare and select in the acceptance cycle, so the table state
  // of that cycle (before any write in it lands) decides the result.
  lpm_match #(
    .ENTRIES(ENTRIES), .ADDR_W(ADDR_W), .LEN_W(LEN_W)
  ) u_match (
    .addr(in_addr), .tbl_valid(tbl_valid), .tbl_prefix(tbl_prefix),
    .tbl_len(tbl_len), .hit_vec(hit_vec)
  );

  lpm_select #(
    .ENTRIES(ENTRIES), .LEN_W(LEN_W), .PORT_W(PORT_W)
  ) u_select (
    .hit_vec(hit_vec), .tbl_len(tbl_len), .tbl_port(tbl_port),
    .any_hit(any_hit), .win_port(win_port)
  );

  assign s2_free  = !out_valid || out_ready;
  assign in_ready = !s1_vld || s2_free;
  assign fire_in  = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_vld  <= 1'b0;
      s1_hit  <= 1'b0;
      s1_port <= '0;
    end else if (in_ready) begin
      s1_vld <= in_valid;
      if (in_valid) begin
        s1_hit  <= any_hit;
        s1_port <= win_port;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_hit   <= 1'b0;
      out_port  <= '0;
    end else if (s2_free) begin
      out_valid <= s1_vld;
      if (s1_vld) begin
        out_hit  <= s1_hit;
        out_port <= s1_port;
      end
    end
  end

endmodule

// File: rtl/lpm_lookup_chk.sv
module lpm_lookup_chk #(
  parameter int PORT_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_ready,
  input logic              fire_in,
  input logic              s1_vld,
  input logic              out_valid,
  input logic              out_ready,
  input logic              out_hit,
  input logic [PORT_W-1:0] out_port
);

  logic rst_prev;
  always_ff @(posedge clk) rst_prev <= !rst_n;

  // R1: after an edge with reset held, the output is idle and input open.
  always_ff @(posedge clk) begin
    if (!rst_n && rst_prev) begin
      p_reset_idle_r1: assert (!out_valid && in_ready);
    end
  end

  // R6: a miss reports port zero.
  p_miss_port_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_hit) |-> (out_port == '0));

  // R8: an accepted lookup occupies the first stage next cycle.
  p_accept_to_s1_r8: assert property (@(posedge clk) disable iff (!rst_n)
    fire_in |=> s1_vld);

  // R8: a first-stage result moves out when the output can take it.
  p_s1_to_out_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (s1_vld && (!out_valid || out_ready)) |=> out_valid);

  // R9: a stalled result is held unchanged.
  p_hold_stall_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_hit) && $stable(out_port)));

  // R9: both stages full and stalled closes the input.
  p_full_blocks_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (s1_vld && out_valid && !out_ready) |-> !in_ready);

endmodule

bind lpm_lookup lpm_lookup_chk #(.PORT_W(PORT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_ready(in_ready), .fire_in(fire_in),
  .s1_vld(s1_vld), .out_valid(out_valid), .out_ready(out_ready),
  .out_hit(out_hit), .out_port(out_port)
);

// File: tb/sim_lpm_lookup.sv
`timescale 1ns/1ps
module sim_lpm_lookup;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_idx = '0;
  logic        wr_valid = 1'b0;
  logic [31:0] wr_prefix = '0;
  logic [5:0]  wr_len = '0;
  logic [3:0]  wr_port = '0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] in_addr = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic        out_hit;
  logic [3:0]  out_port;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  lpm_lookup u0 (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_valid(wr_valid),
    .wr_prefix(wr_prefix), .wr_len(wr_len), .wr_port(wr_port),
    .in_valid(in_valid), .in_ready(in_ready), .in_addr(in_addr),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_hit(out_hit), .out_port(out_port)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic put_route(input int idx, input bit v, input logic [31:0] pfx,
                           input int len, input int port);
    @(negedge clk);
    wr_en = 1'b1; wr_idx = 4'(idx); wr_valid = v;
    wr_prefix = pfx; wr_len = 6'(len); wr_port = 4'(port);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // Single lookup; checks the exact cycle of the result (R8).
  task automatic look(input string tag, input logic [31:0] a, input bit eh, input int ep);
    @(negedge clk);
    chk({tag, " in_ready"}, 32'(in_ready), 1);
    in_valid = 1'b1; in_addr = a;
    @(negedge clk);
    in_valid = 1'b0;
    chk({tag, " R8 not early"}, 32'(out_valid), 0);
    @(negedge clk);
    chk({tag, " R8 valid"}, 32'(out_valid), 1);
    chk({tag, " hit"}, 32'(out_hit), 32'(eh));
    chk({tag, " port"}, 32'(out_port), 32'(ep));
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk("R1 out_valid in reset", 32'(out_valid), 0);
    chk("R1 in_ready in reset", 32'(in_ready), 1);
    rst_n = 1'b1;
    look("R1 R6 empty table miss", 32'h0C52_6465, 1'b0, 0);
  endtask

  task automatic t_longest;
    put_route(0, 1, 32'h8010_7800, 24, 1);  // 128.16.120.0/24
    put_route(1, 1, 32'h0C52_ABCD, 16, 2);  // 12.82.x.x/16, stray low bits
    put_route(2, 1, 32'h8010_0000, 16, 3);  // 128.16.0.0/16
    put_route(3, 1, 32'h8010_786F, 32, 4);  // 128.16.120.111/32
    look("R2 /16 ignores low prefix bits", 32'h0C52_6465, 1'b1, 2);
    look("R2 R3 /24 over /16", 32'h8010_7805, 1'b1, 1);
    look("R3 /32 over /24", 32'h8010_786F, 1'b1, 4);
    look("R2 only /16", 32'h8010_0701, 1'b1, 3);
    look("R6 no match", 32'h0C53_0000, 1'b0, 0);
  endtask

  task automatic t_tie_invalid;
    put_route(9, 1, 32'h0A00_0000, 8, 9);
    put_route(6, 1, 32'h0AFF_FFFF, 8, 6);
    look("R4 tie lower index", 32'h0A02_0304, 1'b1, 6);
    put_route(6, 0, 32'h0A00_0000, 8, 6);
    look("R7 invalid slot skipped", 32'h0A02_0304, 1'b1, 9);
  endtask

  task automatic t_default_clamp;
    put_route(15, 1, 32'hFFFF_FFFF, 0, 7);
    look("R5 default route", 32'h0C53_0000, 1'b1, 7);
    look("R5 R3 longer beats default", 32'h8010_0701, 1'b1, 3);
    put_route(12, 1, 32'h8010_786F, 40, 12);
    look("R11 clamped length ties /32", 32'h8010_786F, 1'b1, 4);
  endtask

  task automatic t_write_timing;
    @(negedge clk);
    wr_en = 1'b1; wr_idx = 4'd10; wr_valid = 1'b1;
    wr_prefix = 32'h2100_0000; wr_len = 6'd8; wr_port = 4'd10;
    in_valid = 1'b1; in_addr = 32'h2101_0101;
    @(negedge clk);
    wr_en = 1'b0;
    chk("R8 in_ready streaming", 32'(in_ready), 1);
    @(negedge clk);
    in_valid = 1'b0;
    chk("R10 same-cycle sees old valid", 32'(out_valid), 1);
    chk("R10 same-cycle sees old port", 32'(out_port), 7);
    @(negedge clk);
    chk("R8 R10 next lookup valid", 32'(out_valid), 1);
    chk("R10 next-cycle sees new port", 32'(out_port), 10);
    @(negedge clk);
    chk("R8 stream drains", 32'(out_valid), 0);
  endtask

  task automatic t_backpressure;
    @(negedge clk);
    out_ready = 1'b0;
    in_valid = 1'b1; in_addr = 32'h0C52_0101;      // -> 2
    @(negedge clk);
    chk("R9 second accepted", 32'(in_ready), 1);
    in_addr = 32'h8010_0701;                       // -> 3
    @(negedge clk);
    in_addr = 32'h6309_0909;                       // -> 7 (default)
    chk("R9 in_ready low when full", 32'(in_ready), 0);
    chk("R9 first result port", 32'(out_port), 2);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk("R9 held valid", 32'(out_valid), 1);
      chk("R9 held port", 32'(out_port), 2);
      chk("R9 still blocked", 32'(in_ready), 0);
    end
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk("R9 second result", 32'(out_port), 3);
    @(negedge clk);
    chk("R9 third result", 32'(out_port), 7);
    chk("R9 third valid", 32'(out_valid), 1);
    @(negedge clk);
    chk("R9 drained", 32'(out_valid), 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    t_reset();
    t_longest();
    t_tie_invalid();
    t_default_clamp();
    t_write_timing();
    t_backpressure();
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule